// File: doc/BRIEF.md
# UART Channel Mode and Control Unit

This unit sits between the register bus of a serial port and the datapath pieces around it: the receive FIFO, the transmit serializer and the baud timer. It holds the control, mode, baud and trigger-level settings. From them it derives whether the receive and transmit paths are running, a break request, and the frame format with its length in bits. It also supplies the divisor terms for the bit-rate generator. Writing the reset and timeout-restart bits of the control register does not store them. Each one instead produces a one-cycle strobe toward the neighbouring logic.

The unit also steers data bytes. A byte comes either from the line receiver or from a CPU write to the data register. According to the two-bit channel mode, it is forwarded as a one-cycle valid strobe to the receive FIFO, to the transmit path, to both, or to neither. A byte aimed at a path that is not running is dropped.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset both paths are inactive, the break request is low, the channel mode is 0 (normal), the baud generator value is 15, the baud divider is 0, both trigger levels are 32, and the default mode register decodes to 8 data bits, even parity and 2 stop bits, which gives a 12-bit frame.
- R2: A control write (byte offset 0x00) with bit 0 set raises rx_rst_pulse for exactly the one cycle after the write. The bit is not stored, so the strobe does not repeat without a new write.
- R3: A control write with bit 1 set raises tx_rst_pulse for exactly the one cycle after the write, and the bit is not stored.
- R4: A control write with bit 6 set raises rto_restart for exactly the one cycle after the write.
- R5: The receive path is active when control bit 2 (enable) is set and bit 3 (disable) is clear. The transmit path is active when bit 4 (enable) is set and bit 5 (disable) is clear. When both the enable and the disable bit of a path are set, the path is inactive.
- R6: break_req is high when control bit 7 (start break) is set and bit 8 (stop break) is clear.
- R7: In mode 0 (normal), mode register bits [9:8] = 0, a line byte goes to the receive FIFO only, and a CPU write to the data register (byte offset 0x30) goes to the transmit path only.
- R8: In mode 1 (echo), a line byte goes to both the receive FIFO and the transmit path, and a CPU data write is dropped.
- R9: In mode 2 (local loopback), a CPU data write goes to the receive FIFO only, and a line byte is dropped.
- R10: In mode 3 (remote loopback), a line byte goes to the transmit path only, and a CPU data write is dropped.
- R11: A byte routed to an inactive path produces no valid strobe on that path. Each routed byte appears with its valid strobe in the cycle after it is offered.
- R12: Mode bits [2:1] select the data length: 3 gives 6 bits, 2 gives 7 bits, any other value gives 8 bits.
- R13: Mode bits [5:3] select parity: 0 is even, 1 is odd, any other value is none. Mode bits [7:6] equal to 3 give 1 stop bit, any other value gives 2. frame_bits is 1 + parity bit + data bits + stop bits.
- R14: Mode bit 0 drives clk_div8_sel. The baud generator value (byte offset 0x18) and the baud divider (byte offset 0x34) are output together with the product generator × (divider + 1). The trigger levels are written at byte offsets 0x20 (receive) and 0x44 (transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | REG_W | Register write data |
| line_rx_valid | input | 1 | Byte received from the line |
| line_rx_data | input | DW | Received line byte |
| rxf_push_valid | output | 1 | Push strobe to the receive FIFO |
| rxf_push_data | output | DW | Byte for the receive FIFO |
| txp_valid | output | 1 | Byte strobe to the transmit path |
| txp_data | output | DW | Byte for the transmit path |
| rx_rst_pulse | output | 1 | One-cycle receive-path reset |
| tx_rst_pulse | output | 1 | One-cycle transmit-path reset |
| rto_restart | output | 1 | One-cycle receive-timeout restart |
| break_req | output | 1 | Line break request |
| rx_active | output | 1 | Receive path running |
| tx_active | output | 1 | Transmit path running |
| chan_mode | output | 2 | Current channel mode |
| clk_div8_sel | output | 1 | Use input clock divided by 8 |
| data_bits | output | 4 | Data bits per frame |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Parity is odd |
| stop_bits | output | 2 | Stop bits per frame |
| frame_bits | output | 4 | Total frame length in bits |
| brg_cd | output | BRG_W | Baud generator value |
| brg_div | output | BDIV_W | Baud divider value |
| baud_divisor | output | BRG_W+BDIV_W+1 | Generator × (divider + 1) |
| rx_trig_lvl | output | TRIG_W | Receive trigger level |
| tx_trig_lvl | output | TRIG_W | Transmit trigger level |

## Verification
The hardest cases to reach are byte drops that happen for two separate reasons: a mode that sends a source nowhere, and a path that has its enable and disable bits set together. In both cases the only evidence is a valid strobe that stays absent. The bench reaches each one with a control or mode write first. It then offers a line byte and a CPU data byte in separate cycles and checks both output strobes in the cycle after each one. The same byte is offered again after the path is re-enabled, which shows that the drop came from the gating and not from the stimulus.

// File: rtl/uart_chan_pkg.sv
// Package: shared encodings for the UART channel mode and control unit.
// Assumes byte-addressed registers; offsets are compared at full address width.
package uart_chan_pkg;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_ECHO   = 2'd1,
        CM_LLOOP  = 2'd2,
        CM_RLOOP  = 2'd3
    } chan_mode_e;

    localparam int unsigned OFF_CTL   = 32'h00;
    localparam int unsigned OFF_MODE  = 32'h04;
    localparam int unsigned OFF_BRG   = 32'h18;
    localparam int unsigned OFF_RTRIG = 32'h20;
    localparam int unsigned OFF_DATA  = 32'h30;
    localparam int unsigned OFF_BDIV  = 32'h34;
    localparam int unsigned OFF_TTRIG = 32'h44;

    // control bit positions
    localparam int unsigned CB_RXRST = 0;
    localparam int unsigned CB_TXRST = 1;
    localparam int unsigned CB_RXEN  = 2;
    localparam int unsigned CB_RXDIS = 3;
    localparam int unsigned CB_TXEN  = 4;
    localparam int unsigned CB_TXDIS = 5;
    localparam int unsigned CB_RTO   = 6;
    localparam int unsigned CB_BRKON = 7;
    localparam int unsigned CB_BRKOFF = 8;

    localparam int unsigned MODE_W = 10;

endpackage

// File: rtl/uart_chan_regs.sv
// uart_chan_regs: holds control, mode, baud and trigger settings.
// Reset and timeout-restart control bits are not stored; each write that sets
// them yields a one-cycle strobe in the following cycle. Unknown offsets are ignored.
module uart_chan_regs
    import uart_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 16,
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8,
    parameter int TRIG_W = 6,
    parameter int BRG_RST  = 15,
    parameter int TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              rx_rst_pulse,
    output logic              tx_rst_pulse,
    output logic              rto_restart,
    output logic              break_req,
    output logic              rx_active,
    output logic              tx_active,
    output logic [MODE_W-1:0] mode_q,
    output logic [BRG_W-1:0]  brg_q,
    output logic [BDIV_W-1:0] bdiv_q,
    output logic [TRIG_W-1:0] rtrig_q,
    output logic [TRIG_W-1:0] ttrig_q
);

    logic rx_en_q, rx_dis_q, tx_en_q, tx_dis_q, brk_on_q, brk_off_q;
    logic hit_ctl, hit_mode, hit_brg, hit_bdiv, hit_rtrig, hit_ttrig;

    // offset decode for this cycle's write
    always_comb begin
        hit_ctl   = reg_wr && (reg_addr == ADDR_W'(OFF_CTL));
        hit_mode  = reg_wr && (reg_addr == ADDR_W'(OFF_MODE));
        hit_brg   = reg_wr && (reg_addr == ADDR_W'(OFF_BRG));
        hit_bdiv  = reg_wr && (reg_addr == ADDR_W'(OFF_BDIV));
        hit_rtrig = reg_wr && (reg_addr == ADDR_W'(OFF_RTRIG));
        hit_ttrig = reg_wr && (reg_addr == ADDR_W'(OFF_TTRIG));
    end

    // stored control bits; reset leaves both paths disabled and break stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q   <= 1'b0;
            rx_dis_q  <= 1'b1;
            tx_en_q   <= 1'b0;
            tx_dis_q  <= 1'b1;
            brk_on_q  <= 1'b0;
            brk_off_q <= 1'b1;
        end else if (hit_ctl) begin
            rx_en_q   <= reg_wdata[CB_RXEN];
            rx_dis_q  <= reg_wdata[CB_RXDIS];
            tx_en_q   <= reg_wdata[CB_TXEN];
            tx_dis_q  <= reg_wdata[CB_TXDIS];
            brk_on_q  <= reg_wdata[CB_BRKON];
            brk_off_q <= reg_wdata[CB_BRKOFF];
        end
    end

    // self-clearing strobes: high only in the cycle after a setting write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rst_pulse <= 1'b0;
            tx_rst_pulse <= 1'b0;
            rto_restart  <= 1'b0;
        end else begin
            rx_rst_pulse <= hit_ctl && reg_wdata[CB_RXRST];
            tx_rst_pulse <= hit_ctl && reg_wdata[CB_TXRST];
            rto_restart  <= hit_ctl && reg_wdata[CB_RTO];
        end
    end

    // format, baud and trigger settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            brg_q   <= BRG_W'(BRG_RST);
            bdiv_q  <= '0;
            rtrig_q <= TRIG_W'(TRIG_RST);
            ttrig_q <= TRIG_W'(TRIG_RST);
        end else begin
            if (hit_mode)  mode_q  <= reg_wdata[MODE_W-1:0];
            if (hit_brg)   brg_q   <= reg_wdata[BRG_W-1:0];
            if (hit_bdiv)  bdiv_q  <= reg_wdata[BDIV_W-1:0];
            if (hit_rtrig) rtrig_q <= reg_wdata[TRIG_W-1:0];
            if (hit_ttrig) ttrig_q <= reg_wdata[TRIG_W-1:0];
        end
    end

    // path gating: disable overrides enable
    always_comb begin
        rx_active = rx_en_q && !rx_dis_q;
        tx_active = tx_en_q && !tx_dis_q;
        break_req = brk_on_q && !brk_off_q;
    end

endmodule

// File: rtl/uart_chan_frame.sv
// uart_chan_frame: decodes the mode register into frame format, frame length
// and the bit-rate divisor product. Purely combinational.
module uart_chan_frame
    import uart_chan_pkg::*;
#(
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8,
    localparam int PROD_W = BRG_W + BDIV_W + 1
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic [BRG_W-1:0]  brg_q,
    input  logic [BDIV_W-1:0] bdiv_q,
    output chan_mode_e        chan_mode,
    output logic              clk_div8_sel,
    output logic [3:0]        data_bits,
    output logic              parity_en,
    output logic              parity_odd,
    output logic [1:0]        stop_bits,
    output logic [3:0]        frame_bits,
    output logic [PROD_W-1:0] baud_divisor
);

    // field decode of the mode register
    always_comb begin
        chan_mode    = chan_mode_e'(mode_q[9:8]);
        clk_div8_sel = mode_q[0];
        unique case (mode_q[2:1])
            2'd3:    data_bits = 4'd6;
            2'd2:    data_bits = 4'd7;
            default: data_bits = 4'd8;
        endcase
        parity_en  = (mode_q[5:3] == 3'd0) || (mode_q[5:3] == 3'd1);
        parity_odd = (mode_q[5:3] == 3'd1);
        stop_bits  = (mode_q[7:6] == 2'd3) ? 2'd1 : 2'd2;
    end

    // total bits on the line: start + parity + data + stop
    always_comb begin
        frame_bits = 4'd1 + {3'd0, parity_en} + data_bits + {2'd0, stop_bits};
    end

    // divisor product for the bit-rate generator
    always_comb begin
        baud_divisor = PROD_W'(brg_q) * (PROD_W'(bdiv_q) + PROD_W'(1));
    end

endmodule

// File: rtl/uart_chan_router.sv
// uart_chan_router: steers line bytes and CPU data writes to the receive FIFO
// and transmit path per channel mode, gated by path activity. Outputs are
// registered: a byte offered in cycle N appears in cycle N+1.
// Assumes at most one line byte and one CPU byte per cycle; no mode routes both
// sources to the same path.
module uart_chan_router
    import uart_chan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_mode_e    chan_mode,
    input  logic          rx_active,
    input  logic          tx_active,
    input  logic          line_rx_valid,
    input  logic [DW-1:0] line_rx_data,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_data,
    output logic          rxf_push_valid,
    output logic [DW-1:0] rxf_push_data,
    output logic          txp_valid,
    output logic [DW-1:0] txp_data
);

    logic line_to_rx, line_to_tx, cpu_to_rx, cpu_to_tx;
    logic rx_go, tx_go;
    logic [DW-1:0] rx_byte, tx_byte;

    // mode routing table
    always_comb begin
        line_to_rx = (chan_mode == CM_NORMAL) || (chan_mode == CM_ECHO);
        line_to_tx = (chan_mode == CM_ECHO)   || (chan_mode == CM_RLOOP);
        cpu_to_rx  = (chan_mode == CM_LLOOP);
        cpu_to_tx  = (chan_mode == CM_NORMAL);
    end

    // select source per destination and apply path gating
    always_comb begin
        rx_go   = rx_active && ((line_rx_valid && line_to_rx) || (cpu_wr && cpu_to_rx));
        tx_go   = tx_active && ((line_rx_valid && line_to_tx) || (cpu_wr && cpu_to_tx));
        rx_byte = cpu_to_rx ? cpu_data : line_rx_data;
        tx_byte = cpu_to_tx ? cpu_data : line_rx_data;
    end

    // output stage toward receive FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxf_push_valid <= 1'b0;
            rxf_push_data  <= '0;
        end else begin
            rxf_push_valid <= rx_go;
            if (rx_go) rxf_push_data <= rx_byte;
        end
    end

    // output stage toward transmit path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txp_valid <= 1'b0;
            txp_data  <= '0;
        end else begin
            txp_valid <= tx_go;
            if (tx_go) txp_data <= tx_byte;
        end
    end

endmodule

// File: rtl/uart_chan_ctrl.sv
// uart_chan_ctrl: top of the UART channel mode and control unit. Ties the
// register block, the frame decoder and the byte router together.
// Assumes REG_W covers BRG_W and the mode register width.
module uart_chan_ctrl
    import uart_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 16,
    parameter int DW     = 8,
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8,
    parameter int TRIG_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    input  logic                      line_rx_valid,
    input  logic [DW-1:0]             line_rx_data,
    output logic                      rxf_push_valid,
    output logic [DW-1:0]             rxf_push_data,
    output logic                      txp_valid,
    output logic [DW-1:0]             txp_data,
    output logic                      rx_rst_pulse,
    output logic                      tx_rst_pulse,
    output logic                      rto_restart,
    output logic                      break_req,
    output logic                      rx_active,
    output logic                      tx_active,
    output logic [1:0]                chan_mode,
    output logic                      clk_div8_sel,
    output logic [3:0]                data_bits,
    output logic                      parity_en,
    output logic                      parity_odd,
    output logic [1:0]                stop_bits,
    output logic [3:0]                frame_bits,
    output logic [BRG_W-1:0]          brg_cd,
    output logic [BDIV_W-1:0]         brg_div,
    output logic [BRG_W+BDIV_W:0]     baud_divisor,
    output logic [TRIG_W-1:0]         rx_trig_lvl,
    output logic [TRIG_W-1:0]         tx_trig_lvl
);

    logic [MODE_W-1:0] mode_q;
    chan_mode_e        mode_e;
    logic              cpu_wr;

    // CPU write to the data register
    always_comb cpu_wr = reg_wr && (reg_addr == ADDR_W'(OFF_DATA));

    uart_chan_regs #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .BRG_W(BRG_W),
        .BDIV_W(BDIV_W), .TRIG_W(TRIG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
        .rto_restart(rto_restart), .break_req(break_req),
        .rx_active(rx_active), .tx_active(tx_active),
        .mode_q(mode_q), .brg_q(brg_cd), .bdiv_q(brg_div),
        .rtrig_q(rx_trig_lvl), .ttrig_q(tx_trig_lvl)
    );

    uart_chan_frame #(
        .BRG_W(BRG_W), .BDIV_W(BDIV_W)
    ) u_frame (
        .mode_q(mode_q), .brg_q(brg_cd), .bdiv_q(brg_div),
        .chan_mode(mode_e), .clk_div8_sel(clk_div8_sel),
        .data_bits(data_bits), .parity_en(parity_en), .parity_odd(parity_odd),
        .stop_bits(stop_bits), .frame_bits(frame_bits),
        .baud_divisor(baud_divisor)
    );

    uart_chan_router #(
        .DW(DW)
    ) u_router (
        .clk(clk), .rst_n(rst_n),
        .chan_mode(mode_e), .rx_active(rx_active), .tx_active(tx_active),
        .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
        .cpu_wr(cpu_wr), .cpu_data(reg_wdata[DW-1:0]),
        .rxf_push_valid(rxf_push_valid), .rxf_push_data(rxf_push_data),
        .txp_valid(txp_valid), .txp_data(txp_data)
    );

    always_comb chan_mode = mode_e;

endmodule

// File: rtl/uart_chan_ctrl_chk.sv
// uart_chan_ctrl_chk: temporal checks on the unit's ports, bound to the top.
module uart_chan_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              line_rx_valid,
    input logic              rxf_push_valid,
    input logic              txp_valid,
    input logic              rx_rst_pulse,
    input logic              tx_rst_pulse,
    input logic              break_req,
    input logic              rx_active,
    input logic              tx_active,
    input logic [1:0]        chan_mode,
    input logic [3:0]        frame_bits
);

    logic ctl_wr;
    always_comb ctl_wr = reg_wr && (reg_addr == '0);

    // R2
    rx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_pulse |-> $past(ctl_wr && reg_wdata[0]));

    // R3
    tx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_pulse |-> $past(ctl_wr && reg_wdata[1]));

    // R6
    break_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_req) |-> $past(ctl_wr));

    // R11
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push_valid |-> $past(rx_active));

    // R11
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txp_valid |-> $past(tx_active));

    // R10
    no_rx_in_rloop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push_valid |-> ($past(chan_mode) != 2'd3));

    // R9
    no_tx_in_lloop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txp_valid |-> ($past(chan_mode) != 2'd2));

    // R7
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txp_valid || rxf_push_valid) |-> $past(reg_wr || line_rx_valid));

    // R13
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bits >= 4'd8) && (frame_bits <= 4'd12));

endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .line_rx_valid(line_rx_valid),
    .rxf_push_valid(rxf_push_valid), .txp_valid(txp_valid),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
    .break_req(break_req), .rx_active(rx_active), .tx_active(tx_active),
    .chan_mode(chan_mode), .frame_bits(frame_bits)
);

// File: tb/uart_chan_ctrl_bench.sv
// Directed bench for uart_chan_ctrl: one task per scenario, each self-checking.
module uart_chan_ctrl_bench;

    localparam int ADDR_W = 8;
    localparam int REG_W  = 16;
    localparam int DW     = 8;
    localparam int BRG_W  = 16;
    localparam int BDIV_W = 8;
    localparam int TRIG_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic line_rx_valid = 1'b0;
    logic [DW-1:0] line_rx_data = '0;
    logic rxf_push_valid, txp_valid, rx_rst_pulse, tx_rst_pulse, rto_restart;
    logic break_req, rx_active, tx_active, clk_div8_sel, parity_en, parity_odd;
    logic [DW-1:0] rxf_push_data, txp_data;
    logic [1:0] chan_mode, stop_bits;
    logic [3:0] data_bits, frame_bits;
    logic [BRG_W-1:0] brg_cd;
    logic [BDIV_W-1:0] brg_div;
    logic [BRG_W+BDIV_W:0] baud_divisor;
    logic [TRIG_W-1:0] rx_trig_lvl, tx_trig_lvl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_chan_ctrl #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .DW(DW),
        .BRG_W(BRG_W), .BDIV_W(BDIV_W), .TRIG_W(TRIG_W)
    ) u_uart_chan_ctrl (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = REG_W'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic line_byte(input int data);
        @(negedge clk);
        line_rx_valid = 1'b1; line_rx_data = DW'(data);
        @(negedge clk);
        line_rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rx_active", rx_active, 0);
        chk("R1 tx_active", tx_active, 0);
        chk("R1 break_req", break_req, 0);
        chk("R1 chan_mode", chan_mode, 0);
        chk("R1 brg_cd", brg_cd, 15);
        chk("R1 brg_div", brg_div, 0);
        chk("R1 rx_trig", rx_trig_lvl, 32);
        chk("R1 tx_trig", tx_trig_lvl, 32);
        chk("R1 data_bits", data_bits, 8);
        chk("R1 parity_en", parity_en, 1);
        chk("R1 frame_bits", frame_bits, 12);
    endtask

    task automatic t_pulses();
        wr(32'h00, 32'h015);
        chk("R2 rx pulse", rx_rst_pulse, 1);
        chk("R3 tx quiet", tx_rst_pulse, 0);
        @(negedge clk);
        chk("R2 rx pulse clears", rx_rst_pulse, 0);
        wr(32'h00, 32'h016);
        chk("R3 tx pulse", tx_rst_pulse, 1);
        chk("R2 rx quiet", rx_rst_pulse, 0);
        @(negedge clk);
        chk("R3 tx pulse clears", tx_rst_pulse, 0);
        wr(32'h00, 32'h054);
        chk("R4 restart", rto_restart, 1);
        @(negedge clk);
        chk("R4 restart clears", rto_restart, 0);
    endtask

    task automatic t_gating();
        wr(32'h00, 32'h014);
        chk("R5 rx on", rx_active, 1);
        chk("R5 tx on", tx_active, 1);
        wr(32'h00, 32'h03C);
        chk("R5 rx dis wins", rx_active, 0);
        chk("R5 tx dis wins", tx_active, 0);
        wr(32'h00, 32'h094);
        chk("R6 break on", break_req, 1);
        wr(32'h00, 32'h194);
        chk("R6 stop wins", break_req, 0);
    endtask

    task automatic t_normal();
        wr(32'h04, 32'h000);
        wr(32'h00, 32'h014);
        line_byte(32'hA5);
        chk("R7 line->rx", rxf_push_valid, 1);
        chk("R7 line rx data", rxf_push_data, 32'hA5);
        chk("R7 line not tx", txp_valid, 0);
        wr(32'h30, 32'h3C);
        chk("R7 cpu->tx", txp_valid, 1);
        chk("R7 cpu tx data", txp_data, 32'h3C);
        chk("R7 cpu not rx", rxf_push_valid, 0);
        @(negedge clk);
        chk("R11 one cycle strobe", txp_valid, 0);
    endtask

    task automatic t_echo();
        wr(32'h04, 32'h100);
        line_byte(32'h5A);
        chk("R8 line->rx", rxf_push_valid, 1);
        chk("R8 line->tx", txp_valid, 1);
        chk("R8 tx data", txp_data, 32'h5A);
        wr(32'h30, 32'h11);
        chk("R8 cpu drop tx", txp_valid, 0);
        chk("R8 cpu drop rx", rxf_push_valid, 0);
    endtask

    task automatic t_lloop();
        wr(32'h04, 32'h200);
        line_byte(32'h22);
        chk("R9 line drop rx", rxf_push_valid, 0);
        chk("R9 line drop tx", txp_valid, 0);
        wr(32'h30, 32'h77);
        chk("R9 cpu->rx", rxf_push_valid, 1);
        chk("R9 cpu rx data", rxf_push_data, 32'h77);
        chk("R9 cpu not tx", txp_valid, 0);
    endtask

    task automatic t_rloop();
        wr(32'h04, 32'h300);
        line_byte(32'h81);
        chk("R10 line->tx", txp_valid, 1);
        chk("R10 tx data", txp_data, 32'h81);
        chk("R10 line not rx", rxf_push_valid, 0);
        wr(32'h30, 32'h44);
        chk("R10 cpu drop", txp_valid, 0);
    endtask

    task automatic t_path_off();
        wr(32'h04, 32'h000);
        wr(32'h00, 32'h01C);
        line_byte(32'h99);
        chk("R11 rx off drop", rxf_push_valid, 0);
        wr(32'h00, 32'h034);
        wr(32'h30, 32'h66);
        chk("R11 tx off drop", txp_valid, 0);
        wr(32'h00, 32'h014);
        line_byte(32'h99);
        chk("R11 rx back on", rxf_push_valid, 1);
        wr(32'h30, 32'h66);
        chk("R11 tx back on", txp_valid, 1);
    endtask

    task automatic t_format();
        wr(32'h04, 32'h006);
        chk("R12 six bits", data_bits, 6);
        chk("R13 frame 10", frame_bits, 10);
        wr(32'h04, 32'h004);
        chk("R12 seven bits", data_bits, 7);
        wr(32'h04, 32'h0C8);
        chk("R13 odd", parity_odd, 1);
        chk("R13 one stop", stop_bits, 1);
        chk("R13 frame 11", frame_bits, 11);
        wr(32'h04, 32'h0E6);
        chk("R13 no parity", parity_en, 0);
        chk("R13 frame 8", frame_bits, 8);
        wr(32'h04, 32'h001);
        chk("R14 div8 sel", clk_div8_sel, 1);
        wr(32'h18, 32'h000A);
        wr(32'h34, 32'h03);
        chk("R14 brg", brg_cd, 10);
        chk("R14 product", baud_divisor, 40);
        wr(32'h20, 32'h05);
        wr(32'h44, 32'h09);
        chk("R14 rx trig", rx_trig_lvl, 5);
        chk("R14 tx trig", tx_trig_lvl, 9);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulses();
        t_gating();
        t_normal();
        t_echo();
        t_lloop();
        t_rloop();
        t_path_off();
        t_format();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule